// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 64 interrupt request wires and drives one interrupt line toward a processor. Each request wire is first passed through a two-flop synchroniser. It is then qualified by its own trigger mode: active-low level, active-high level, falling edge or rising edge. In either edge mode a detected edge is held in a sticky latch until software clears it. Every source also carries a priority level from 0 to 7. Level 0 switches the source off, and a source competes only when its level is strictly above a programmable threshold.

Among the qualifying sources the one with the highest level wins. When levels tie, the lower source number wins. A status word reports the winner's number, or sets a "nothing pending" flag. Source 0 is reserved and never wins. A global enable gates the outgoing interrupt line.

Software reaches all of this through a flat, word-addressed register port. A write takes effect on the clock edge where `sel` and `we` are high. Reads return data combinationally for the current `addr`.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source 0 is never pending, whatever its input, mode and level. The status word therefore never reports source 0 as the winner.
- R2: Mode 00 makes a source pending while its input is low. Mode 01 makes it pending while its input is high. A level change on an input is reflected at `cpu_irq` and in the status word no later than 3 clock edges after it occurs.
- R3: Mode 10 latches a high-to-low transition and mode 11 latches a low-to-high transition. The latch keeps the source pending after the input returns to its idle value, and only an edge-clear write drops it.
- R4: An edge-clear write goes to 0x08 for sources 0..31 or to 0x10 for sources 32..63. Within that bank, bit 8 set together with index bits 3:0 clears the latch of source base+index. Bit 24 set together with index bits 19:16 clears the latch of source base+16+index. A write whose enable bit (8 or 24) is clear has no effect on that half.
- R5: A source is forwarded only when its level is strictly greater than the threshold held in bits 2:0 at 0x04. Level 0 therefore never forwards.
- R6: Bit 0 at 0x00 is the global enable. While it is 0, `cpu_irq` stays low.
- R7: The status word at 0x0C, read-only, sets bit 16 when no source qualifies and then holds 0 in bits 5:0. Otherwise bit 16 is 0 and bits 5:0 give the highest-level qualifying source, with the lowest number winning a tie. Status is reported regardless of the global enable, and `cpu_irq` is high exactly when the enable is set and bit 16 is clear.
- R8: After reset all modes are 00, all levels are 0, the threshold is 0 and the enable is 0. Status reads 0x0001_0000 and `cpu_irq` is low.
- R9: Mode register k sits at 0x20+4k and holds source 16k+j in bits 2j+1:2j. Level register k sits at 0x40+4k and holds source 4k+j in bits 8j+2:8j, and the other bits of each 8-bit slot read 0. Both kinds of register read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 64 | Raw interrupt request inputs, asynchronous |
| sel | input | 1 | Register access strobe |
| we | input | 1 | Write when high together with sel |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is an edge latch that must outlive its input while other sources compete for the win. To get there, an edge is made, the input is returned to idle, and the levels, threshold and modes of other sources are then changed around it. Clears go to all four bank/half combinations, and clears are also written with the enable bit missing. Beyond these directed cases, a fixed-seed random mix of mode, level, threshold, input and clear operations keeps many sources pending at equal and unequal levels, so that tie-breaks and the threshold boundary come up often.

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl #(
  parameter int NSRC   = 64,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cpu_irq
);
  localparam int IDXW = $clog2(NSRC);
  localparam int NMR  = NSRC / 16;
  localparam int NLR  = NSRC / 4;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_ECA  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_ECB  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(8'h40);

  logic            en_q;
  logic [2:0]      thr_q;
  logic [1:0]      mode_q [NSRC];
  logic [2:0]      lvl_q  [NSRC];
  logic [NSRC-1:0] s1, s2, s3, lat_q, pend, clr_v;
  logic            found;
  logic [IDXW-1:0] win_idx;
  logic [2:0]      win_lvl;

  wire wr = sel & we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s3, s2, s1} <= '0;
    else        {s3, s2, s1} <= {s2, s1, irq_in};

  always_comb
    for (int i = 0; i < NSRC; i++) begin
      int b, h, x;
      b = i / 32; h = (i / 16) % 2; x = i % 16;
      clr_v[i] = wr && addr == (b != 0 ? A_ECB : A_ECA) &&
                 wdata[8 + 16*h] && wdata[16*h +: 4] == 4'(x);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat_q <= '0;
    else
      for (int i = 0; i < NSRC; i++)
        if (mode_q[i][1] && (mode_q[i][0] ? (s2[i] & ~s3[i]) : (~s2[i] & s3[i])))
          lat_q[i] <= 1'b1;
        else if (clr_v[i])
          lat_q[i] <= 1'b0;

  always_comb
    for (int i = 0; i < NSRC; i++)
      pend[i] = (i != 0) && (mode_q[i][1] ? lat_q[i] : (mode_q[i][0] ? s2[i] : ~s2[i]));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 1'b0;
      thr_q <= '0;
      for (int i = 0; i < NSRC; i++) begin
        mode_q[i] <= 2'b00;
        lvl_q[i]  <= 3'd0;
      end
    end else if (wr) begin
      if (addr == A_CTRL) en_q  <= wdata[0];
      if (addr == A_THR)  thr_q <= wdata[2:0];
      for (int i = 0; i < NSRC; i++) begin
        if (addr == A_MODE + ADDR_W'(4 * (i / 16))) mode_q[i] <= wdata[2*(i%16) +: 2];
        if (addr == A_LVL  + ADDR_W'(4 * (i / 4)))  lvl_q[i]  <= wdata[8*(i%4) +: 3];
      end
    end

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = thr_q;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && lvl_q[i] > win_lvl) begin
        found   = 1'b1;
        win_idx = IDXW'(i);
        win_lvl = lvl_q[i];
      end
  end

  assign cpu_irq = en_q & found;

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) rdata[0] = en_q;
    if (addr == A_THR)  rdata[2:0] = thr_q;
    if (addr == A_STAT) begin
      rdata[16]       = ~found;
      rdata[IDXW-1:0] = win_idx;
    end
    for (int k = 0; k < NMR; k++)
      if (addr == A_MODE + ADDR_W'(4 * k))
        for (int j = 0; j < 16; j++) rdata[2*j +: 2] = mode_q[16*k + j];
    for (int k = 0; k < NLR; k++)
      if (addr == A_LVL + ADDR_W'(4 * k))
        for (int j = 0; j < 4; j++) rdata[8*j +: 3] = lvl_q[4*k + j];
  end

  p_src0_never_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> win_idx != '0);
  p_latch_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lat_q) & ~lat_q & ~$past(clr_v)) == '0));
  p_above_thresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> win_lvl > thr_q);
  p_off_is_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && addr == A_CTRL && !wdata[0]) |-> !cpu_irq);
  p_irq_has_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> found && pend[win_idx]);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic        clk = 0, rst_n = 0, sel = 0, we = 0;
  logic [63:0] irq_in = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        cpu_irq;
  int n_chk = 0, n_bad = 0;

  logic [1:0]  m_mode [64];
  logic [2:0]  m_lvl  [64];
  logic        m_lat  [64];
  logic [2:0]  m_thr;
  logic        m_en;

  irq_prio_ctrl u0 (.clk, .rst_n, .irq_in, .sel, .we, .addr, .wdata, .rdata, .cpu_irq);

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [31:0] mode_word(int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 16; j++) w[2*j +: 2] = m_mode[16*k + j];
    return w;
  endfunction

  function automatic logic [31:0] lvl_word(int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++) w[8*j +: 3] = m_lvl[4*k + j];
    return w;
  endfunction

  task automatic set_mode(int i, logic [1:0] m);
    m_mode[i] = m; wr(8'h20 + 8'(4 * (i / 16)), mode_word(i / 16));
  endtask

  task automatic set_lvl(int i, logic [2:0] l);
    m_lvl[i] = l; wr(8'h40 + 8'(4 * (i / 4)), lvl_word(i / 4));
  endtask

  task automatic set_thr(logic [2:0] t); m_thr = t; wr(8'h04, {29'd0, t}); endtask
  task automatic set_en(logic e);        m_en = e;  wr(8'h00, {31'd0, e}); endtask

  task automatic edge_clear(int i, logic ena);
    int h = (i / 16) % 2;
    logic [31:0] w = (32'(ena) << (8 + 16*h)) | (32'(i % 16) << (16*h));
    wr(i >= 32 ? 8'h10 : 8'h08, w);
    if (ena) m_lat[i] = 1'b0;
  endtask

  task automatic set_in(logic [63:0] v);
    for (int i = 0; i < 64; i++)
      if (v[i] != irq_in[i] && m_mode[i][1] && (v[i] == m_mode[i][0])) m_lat[i] = 1'b1;
    @(negedge clk); irq_in = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_status();
    logic [2:0] best = m_thr;
    logic [31:0] s = 32'h0001_0000;
    for (int i = 1; i < 64; i++) begin
      logic p = m_mode[i][1] ? m_lat[i] : (m_mode[i][0] ? irq_in[i] : ~irq_in[i]);
      if (p && m_lvl[i] > best) begin best = m_lvl[i]; s = 32'(i); end
    end
    return s;
  endfunction

  task automatic check_all(string req);
    logic [31:0] s, e;
    rd(8'h0C, s);
    e = exp_status();
    check(req, s, e);
    check({req, " cpu_irq"}, {31'd0, cpu_irq}, {31'd0, m_en && !e[16]});
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(1234));
    for (int i = 0; i < 64; i++) begin m_mode[i] = 0; m_lvl[i] = 0; m_lat[i] = 0; end
    m_thr = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R8 reset state
    rd(8'h00, d); check("R8 enable", d, 0);
    rd(8'h04, d); check("R8 thresh", d, 0);
    rd(8'h24, d); check("R8 mode", d, 0);
    rd(8'h7C, d); check("R8 level", d, 0);
    rd(8'h0C, d); check("R8 status", d, 32'h0001_0000);
    check("R8 cpu_irq", {31'd0, cpu_irq}, 0);

    // R9 layout readback
    set_mode(17, 2'b01); set_mode(18, 2'b10);
    rd(8'h24, d); check("R9 mode word", d, 32'h0000_0024);
    wr(8'h4C, 32'hFFFF_FFFF);
    for (int j = 0; j < 4; j++) m_lvl[12 + j] = 3'd7;
    rd(8'h4C, d); check("R9 level slots", d, 32'h0707_0707);
    set_mode(17, 2'b00); set_mode(18, 2'b00);
    for (int j = 0; j < 4; j++) set_lvl(12 + j, 0);

    // R2 level modes
    set_en(1);
    set_lvl(9, 3); check_all("R2 low-active with input low");
    set_in(64'h200); check_all("R2 low-active released");
    set_mode(9, 2'b01); check_all("R2 high-active asserted");
    @(negedge clk); irq_in = 0; repeat (2) @(posedge clk); #1;
    check("R2 latency", {31'd0, cpu_irq}, 0);
    set_in(0); check_all("R2 high-active released");
    set_lvl(9, 0);

    // R1 reserved source
    set_mode(0, 2'b01); set_lvl(0, 7); set_in(64'h1);
    check_all("R1 source 0 silent");
    set_in(0); set_lvl(0, 0); set_mode(0, 0);

    // R3 edge latch persistence, R4 clear in all four places
    set_lvl(5, 3); set_mode(5, 2'b11);
    set_in(64'h20); set_in(0); check_all("R3 rising latch held");
    set_lvl(6, 5); check_all("R3 other source higher");
    set_lvl(6, 0); check_all("R3 latch still held");
    edge_clear(5, 0); check_all("R4 clear without enable bit ignored");
    edge_clear(5, 1); check_all("R4 clear bank A low half");
    set_lvl(20, 4); set_mode(20, 2'b10); set_in(64'h10_0000); set_in(0);
    check_all("R3 falling latch");
    edge_clear(20, 1); check_all("R4 clear bank A high half");
    set_lvl(40, 2); set_mode(40, 2'b11); set_in(64'h100_0000_0000);
    edge_clear(8, 1); check_all("R4 wrong bank no effect");
    edge_clear(40, 1); check_all("R4 clear bank B low half");
    set_lvl(60, 6); set_mode(60, 2'b11); set_in(64'h1100_0000_0000_0000);
    edge_clear(60, 1); check_all("R4 clear bank B high half");
    set_in(0);

    // R7 tie-break, R5 threshold boundary
    set_mode(40, 2'b00); set_mode(60, 2'b00); set_lvl(40, 6); set_lvl(60, 6);
    set_lvl(33, 6); set_mode(33, 2'b00); check_all("R7 tie lowest number");
    set_thr(6); check_all("R5 level equal to threshold blocked");
    set_lvl(60, 7); check_all("R5 level above threshold");
    set_en(0); check_all("R6 disabled quiet");
    set_en(1); set_thr(0);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 5);
      int s = $urandom_range(0, 63);
      case (op)
        0: set_lvl(s, 3'($urandom_range(0, 7)));
        1: set_mode(s, 2'($urandom_range(0, 3)));
        2: set_in(irq_in ^ (64'd1 << s) ^ (64'd1 << $urandom_range(0, 63)));
        3: edge_clear(s, 1'($urandom_range(0, 3) != 0));
        4: set_thr(3'($urandom_range(0, 4)));
        default: set_en(1'($urandom_range(0, 5) != 0));
      endcase
      check_all(op == 4 ? "R5 random" : op == 3 ? "R4 random" : "R7 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule